// File: doc/BRIEF.md
# Four-Lane Frame Alignment Checker

This block observes four byte-wide tributary lanes that are meant to run in lock-step. Each lane brings a data byte, a parity bit and a frame pulse that marks the first payload byte of that lane's frame. On every rising edge of the shared clock the block checks the parity of each lane. It also checks that the four frame pulses arrive together, and at the interval the frame length sets.

The block raises an out-of-frame flag when the lanes drift apart, when a pulse comes early or late, or when an expected pulse does not come at all. A separate flag reports that a whole frame period has passed with no pulse on any lane. Recovery is deliberately slow: two aligned, on-time frames in a row are needed before the out-of-frame flag drops. A disable input turns off the alignment judgement, for example while the upstream sources are being brought up. Realigning or buffering the lanes is left to other logic.

Top module: `frame_align_chk`

## Requirements
- R1: Each lane's byte plus its parity bit must have odd parity. For a lane whose nine sampled bits have even parity, bit i of `par_err` (bit 0 is lane A, bit 3 is lane D) is high for exactly the one cycle after that byte is sampled.
- R2: While all four pulses arrive in the same cycle and exactly `FRAME_LEN` cycles after the previous pulse event, `oof` stays low.
- R3: A cycle in which some, but not all, of the lane pulses are high sets `oof` in the following cycle.
- R4: A pulse event that comes a number of cycles other than `FRAME_LEN` after the previous pulse event sets `oof` in the following cycle.
- R5: If no pulse arrives in the cycle where one is due (`FRAME_LEN` cycles after the last pulse event), `oof` and `nofp` both rise in the following cycle.
- R6: Once set, `nofp` stays high until a pulse appears on any lane, and it is low in the cycle after that pulse.
- R7: After `oof` is set, it clears only in the cycle after the second consecutive pulse event in which all four pulses coincide and arrive on time.
- R8: While `chk_dis` is high, `oof` is low from the next cycle on and no pulse pattern can set it. Parity reporting is unaffected.
- R9: A synchronous active-high `rst` clears `oof`, `nofp`, `par_err` and the period counter. After reset, `nofp` rises only once a full `FRAME_LEN` has passed without a pulse.
- R10: The first pulse event after reset, or after a period with no reference, is accepted as the timing reference whatever its arrival time, provided all four pulses coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared lane clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| chk_dis | input | 1 | High disables the alignment judgement |
| lane_byte | input | LANES x BYTE_W | Data byte for each lane, index 0 is lane A |
| lane_par | input | LANES | Parity bit for each lane |
| lane_fp | input | LANES | Frame pulse for each lane, bit 0 is lane A |
| par_err | output | LANES | One-cycle parity error pulse for each lane |
| oof | output | 1 | Lanes are out of frame |
| nofp | output | 1 | No frame pulse seen for a full period |

## Verification
A wrong period count shows up at the ports as a spurious `oof` one cycle after a pulse that is on time, or as an `oof` and `nofp` rise that comes too early or too late around the due cycle. The bench therefore probes the cycle right before and right after the due point. A corrupted recovery streak shows up as `oof` dropping after one good frame instead of two, which the bench observes frame by frame. Parity faults appear on the lane bit one cycle after the byte, so lane ordering and pulse width are checked in that cycle and the one after it.

// File: rtl/frame_align_pkg.sv
package frame_align_pkg;

    typedef struct packed {
        logic       oof;
        logic [1:0] streak;
    } judge_state_t;

endpackage

// File: rtl/lane_parity_chk.sv
module lane_parity_chk #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              par_in,
    output logic              err
);

    logic err_d, err_q;

    always_comb begin
        err_d = ~(^{byte_in, par_in});
        if (rst) begin
            err_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        err_q <= err_d;
    end

    assign err = err_q;

    a_r1_even_word_flags: assert property (@(posedge clk) disable iff (rst)
        !(^{byte_in, par_in}) |=> err);

endmodule

// File: rtl/frame_period_timer.sv
module frame_period_timer #(
    parameter int FRAME_LEN = 9720
) (
    input  logic clk,
    input  logic rst,
    input  logic any_fp,
    output logic ref_valid,
    output logic on_time,
    output logic nofp
);

    localparam int CW = $clog2(FRAME_LEN + 1);
    localparam logic [CW-1:0] EXPECT = CW'(FRAME_LEN - 1);
    localparam logic [CW-1:0] SAT    = CW'(FRAME_LEN);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ref_ok;
        logic          nofp;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (any_fp) begin
            tmr_d.cnt    = '0;
            tmr_d.ref_ok = 1'b1;
            tmr_d.nofp   = 1'b0;
        end else begin
            if (tmr_q.cnt != SAT) begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
            if (tmr_q.cnt >= EXPECT) begin
                tmr_d.nofp = 1'b1;
            end
        end
        if (rst) begin
            tmr_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        tmr_q <= tmr_d;
    end

    assign ref_valid = tmr_q.ref_ok;
    assign on_time   = (tmr_q.cnt == EXPECT);
    assign nofp      = tmr_q.nofp;

    a_r6_nofp_drops: assert property (@(posedge clk) disable iff (rst)
        any_fp |=> !nofp);

    a_r9_count_bounded: assert property (@(posedge clk) disable iff (rst)
        tmr_q.cnt <= SAT);

endmodule

// File: rtl/sync_judge.sv
module sync_judge
    import frame_align_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic chk_dis,
    input  logic all_fp,
    input  logic any_fp,
    input  logic ref_valid,
    input  logic on_time,
    output logic oof
);

    judge_state_t js_d, js_q;
    logic good_ev, bad_ev;

    always_comb begin
        good_ev = all_fp && (!ref_valid || on_time);
        bad_ev  = (any_fp && !good_ev) || (!any_fp && ref_valid && on_time);
        js_d    = js_q;
        if (chk_dis) begin
            js_d = '0;
        end else if (bad_ev) begin
            js_d.oof    = 1'b1;
            js_d.streak = 2'd0;
        end else if (good_ev) begin
            if (js_q.streak != 2'd2) begin
                js_d.streak = js_q.streak + 2'd1;
            end
            if (js_q.streak != 2'd0) begin
                js_d.oof = 1'b0;
            end
        end
        if (rst) begin
            js_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        js_q <= js_d;
    end

    assign oof = js_q.oof;

    a_r8_disable_holds_low: assert property (@(posedge clk) disable iff (rst)
        chk_dis |=> !oof);

    a_r7_clear_needs_aligned: assert property (@(posedge clk) disable iff (rst)
        $fell(oof) |-> ($past(chk_dis) || $past(all_fp)));

endmodule

// File: rtl/frame_align_chk.sv
module frame_align_chk #(
    parameter int LANES     = 4,
    parameter int BYTE_W    = 8,
    parameter int FRAME_LEN = 9720
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         chk_dis,
    input  logic [LANES-1:0][BYTE_W-1:0] lane_byte,
    input  logic [LANES-1:0]             lane_par,
    input  logic [LANES-1:0]             lane_fp,
    output logic [LANES-1:0]             par_err,
    output logic                         oof,
    output logic                         nofp
);

    logic all_fp, any_fp;
    logic ref_valid, on_time;

    assign all_fp = &lane_fp;
    assign any_fp = |lane_fp;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_parity_chk #(.BYTE_W(BYTE_W)) u_par (
            .clk     (clk),
            .rst     (rst),
            .byte_in (lane_byte[g]),
            .par_in  (lane_par[g]),
            .err     (par_err[g])
        );
    end

    frame_period_timer #(.FRAME_LEN(FRAME_LEN)) u_tmr (
        .clk       (clk),
        .rst       (rst),
        .any_fp    (any_fp),
        .ref_valid (ref_valid),
        .on_time   (on_time),
        .nofp      (nofp)
    );

    sync_judge u_judge (
        .clk       (clk),
        .rst       (rst),
        .chk_dis   (chk_dis),
        .all_fp    (all_fp),
        .any_fp    (any_fp),
        .ref_valid (ref_valid),
        .on_time   (on_time),
        .oof       (oof)
    );

    a_r5_nofp_with_oof: assert property (@(posedge clk) disable iff (rst || chk_dis)
        (!any_fp && ref_valid && on_time) |=> (oof && nofp));

endmodule

// File: tb/frame_align_chk_tb.sv
module frame_align_chk_tb_top;

    localparam int F = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            chk_dis = 1'b0;
    logic [3:0][7:0] lane_byte;
    logic [3:0]      lane_par;
    logic [3:0]      lane_fp = '0;
    logic [3:0]      par_err;
    logic            oof, nofp;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    frame_align_chk #(.LANES(4), .BYTE_W(8), .FRAME_LEN(F)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .chk_dis   (chk_dis),
        .lane_byte (lane_byte),
        .lane_par  (lane_par),
        .lane_fp   (lane_fp),
        .par_err   (par_err),
        .oof       (oof),
        .nofp      (nofp)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic good_bytes();
        for (int i = 0; i < 4; i++) begin
            lane_byte[i] = 8'h5A ^ 8'(i * 37);
            lane_par[i]  = ~^lane_byte[i];
        end
    endtask

    task automatic step(input logic [3:0] fp);
        lane_fp = fp;
        @(negedge clk);
        lane_fp = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(4'h0);
    endtask

    task automatic pulse_after(input int gap, input logic [3:0] fp);
        idle(gap - 1);
        step(fp);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R9 oof after reset", oof, 0);
        check("R9 nofp after reset", nofp, 0);
        check("R9 par_err after reset", par_err, 0);
    endtask

    task automatic t_aligned();
        step(4'hF);
        check("R10 first aligned pulse", oof, 0);
        for (int k = 0; k < 3; k++) begin
            pulse_after(F, 4'hF);
            check("R2 aligned frame oof", oof, 0);
            check("R2 aligned frame nofp", nofp, 0);
        end
    endtask

    task automatic t_skew();
        pulse_after(F, 4'b0111);
        check("R3 lane D missing", oof, 1);
        pulse_after(F, 4'hF);
        check("R7 one good frame", oof, 1);
        pulse_after(F, 4'hF);
        check("R7 two good frames", oof, 0);
    endtask

    task automatic t_period();
        pulse_after(F - 3, 4'hF);
        check("R4 early pulse", oof, 1);
        pulse_after(F, 4'hF);
        check("R7 after early one good", oof, 1);
        pulse_after(F, 4'hF);
        check("R7 after early two good", oof, 0);
    endtask

    task automatic t_missing();
        idle(F - 1);
        check("R5 before due oof", oof, 0);
        check("R5 before due nofp", nofp, 0);
        step(4'h0);
        check("R5 missed pulse oof", oof, 1);
        check("R5 missed pulse nofp", nofp, 1);
        idle(3);
        check("R6 nofp held", nofp, 1);
        step(4'b1000);
        check("R6 nofp cleared by lane D", nofp, 0);
        check("R3 single lane late", oof, 1);
        pulse_after(F, 4'hF);
        check("R7 recovery first", oof, 1);
        pulse_after(F, 4'hF);
        check("R7 recovery second", oof, 0);
    endtask

    task automatic t_disable();
        pulse_after(F, 4'b0110);
        check("R3 two lanes only", oof, 1);
        chk_dis = 1'b1;
        step(4'h0);
        check("R8 disable clears", oof, 0);
        idle(F - 3);
        lane_par[2] = ~lane_par[2];
        step(4'b0011);
        check("R8 mismatch ignored", oof, 0);
        check("R8 parity still reported", par_err, 4'b0100);
        good_bytes();
        chk_dis = 1'b0;
        pulse_after(F, 4'hF);
        check("R8 re-enable on time", oof, 0);
    endtask

    task automatic t_parity();
        good_bytes();
        step(4'h0);
        check("R1 clean bytes", par_err, 0);
        lane_par[1] = ~lane_par[1];
        step(4'h0);
        check("R1 lane B error", par_err, 4'b0010);
        good_bytes();
        step(4'h0);
        check("R1 one-cycle pulse", par_err, 0);
        lane_byte[0] = 8'h00; lane_par[0] = 1'b0;
        lane_byte[3] = 8'hFF; lane_par[3] = 1'b0;
        step(4'h0);
        check("R1 lanes A and D error", par_err, 4'b1001);
        lane_par[0] = 1'b1;
        lane_par[3] = 1'b1;
        step(4'h0);
        check("R1 odd boundary bytes clean", par_err, 0);
        good_bytes();
    endtask

    task automatic t_midreset();
        step(4'b0001);
        check("R3 lane A alone", oof, 1);
        do_reset();
        check("R9 reset clears oof", oof, 0);
        check("R9 reset clears nofp", nofp, 0);
        idle(F - 1);
        check("R9 counter restarted", nofp, 0);
        step(4'h0);
        check("R9 nofp after full period", nofp, 1);
        check("R9 no oof without reference", oof, 0);
        idle(5);
        step(4'hF);
        check("R10 late first pulse accepted", oof, 0);
        check("R6 nofp cleared", nofp, 0);
        pulse_after(F, 4'hF);
        check("R2 new reference on time", oof, 0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        good_bytes();
        @(negedge clk);
        t_reset();
        t_aligned();
        t_skew();
        t_period();
        t_missing();
        t_disable();
        t_parity();
        t_midreset();
        finish_run();
    end

endmodule